// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block caches recent virtual-to-physical page translations so that a load, store or instruction fetch can be translated without walking the page table in memory. A lookup presents a 32-bit virtual address. The block splits that address into a page number and a 4 KB page offset, and compares the page number against every stored entry at once. The lookup completes in the same cycle. On a hit, the physical address is the stored physical page number joined to the unchanged offset. On a miss, the block raises a miss flag so that an outside walker can fetch the mapping.

The walker installs a mapping through the refill port. A refill that names a page already present updates that entry in place. Otherwise it takes the lowest free slot. Once every slot is valid, it takes the slot chosen by a round-robin pointer. A flush input empties the whole table in one cycle.

Top module: `tlb_fa`

## Requirements
- R1: The page offset is the low 12 bits of `lk_vaddr` and the page number is the upper 20 bits. On a hit, `lk_paddr[11:0]` equals `lk_vaddr[11:0]` for any offset value.
- R2: When `lk_valid` is high and a valid entry holds the page number of `lk_vaddr`, the block sets `lk_hit`=1 and `lk_miss`=0 in the same cycle, and sets `lk_paddr` = {stored PPN, offset}. Example: page 0xFC519 mapped to 0x00152 turns 0xFC51908B into 0x0015208B.
- R3: When `lk_valid` is high and no valid entry holds the page number, the block sets `lk_miss`=1, `lk_hit`=0 and `lk_paddr`=0.
- R4: When `lk_valid` is low, both `lk_hit` and `lk_miss` are 0.
- R5: Reset (`rst_n` low, sampled on the clock edge) clears every valid bit, so every lookup during and after reset misses until the next refill.
- R6: A refill takes effect on the clock edge that samples `fill_en`. A lookup for the same page in that cycle reports a miss, and the same lookup hits in the following cycle.
- R7: While some slot is invalid, a refill of a new page writes the lowest-numbered invalid slot and evicts no valid entry.
- R8: When all slots are valid, a refill of a new page overwrites the slot at the round-robin pointer. The pointer starts at slot 0, advances by one after each such replacement, and wraps from the last slot to slot 0.
- R9: `flush` invalidates all entries in one cycle and returns the round-robin pointer to slot 0. A refill requested in the same cycle as `flush` is dropped.
- R10: A refill whose page number is already held by a valid entry rewrites that entry's PPN. No other entry is evicted and the round-robin pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Lookup requested, no translation held |
| lk_paddr | output | 32 | Translated physical address, zero when not a hit |
| fill_en | input | 1 | Install a translation at the next edge |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| flush | input | 1 | Invalidate all entries |

## Verification
The assertions check several things on every cycle: that hit and miss never assert together, that idle cycles raise neither flag, that a hit carries the offset through untouched, that nothing hits in the cycle after a flush, and that a page refilled in one cycle hits with its new PPN in the next. Which slot a refill chooses can only be seen over a sequence of operations. The bench's scenarios therefore show the lowest-free-slot choice, the order of round-robin eviction and its wrap, in-place update of a duplicate page, and the return of the pointer to slot 0 after a flush. They do this by observing which earlier translations stop hitting.

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PG_BITS = 12,
  parameter int ENTRIES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_valid,
  input  logic [VA_W-1:0]         lk_vaddr,
  output logic                    lk_hit,
  output logic                    lk_miss,
  output logic [PA_W-1:0]         lk_paddr,
  input  logic                    fill_en,
  input  logic [VA_W-PG_BITS-1:0] fill_vpn,
  input  logic [PA_W-PG_BITS-1:0] fill_ppn,
  input  logic                    flush
);
  localparam int VPN_W = VA_W - PG_BITS;
  localparam int PPN_W = PA_W - PG_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   vtag [ENTRIES];
  logic [PPN_W-1:0]   pfn  [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr;

  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] lk_match, fl_match;
  logic [PPN_W-1:0]   hit_ppn;

  assign lk_vpn = lk_vaddr[VA_W-1:PG_BITS];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = vld[g] && (vtag[g] == lk_vpn);
    assign fl_match[g] = vld[g] && (vtag[g] == fill_vpn);
  end

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) hit_ppn = hit_ppn | pfn[i];
  end

  assign lk_hit   = lk_valid && (|lk_match);
  assign lk_miss  = lk_valid && !(|lk_match);
  assign lk_paddr = lk_hit ? {hit_ppn, lk_vaddr[PG_BITS-1:0]} : '0;

  logic             dup_any, free_any;
  logic [IDX_W-1:0] dup_idx, free_idx, victim;

  always_comb begin
    dup_any  = 1'b0;
    dup_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!dup_any && fl_match[i]) begin
        dup_any = 1'b1;
        dup_idx = IDX_W'(i);
      end
      if (!free_any && !vld[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    victim = dup_any ? dup_idx : (free_any ? free_idx : rr_ptr);
  end

  wire do_fill = fill_en && !flush && rst_n;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld    <= '0;
      rr_ptr <= '0;
    end else if (fill_en) begin
      vld[victim] <= 1'b1;
      if (!dup_any && !free_any)
        rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      vtag[victim] <= fill_vpn;
      pfn[victim]  <= fill_ppn;
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PG_BITS = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    lk_valid,
  input logic [VA_W-1:0]         lk_vaddr,
  input logic                    lk_hit,
  input logic                    lk_miss,
  input logic [PA_W-1:0]         lk_paddr,
  input logic                    fill_en,
  input logic [VA_W-PG_BITS-1:0] fill_vpn,
  input logic [PA_W-PG_BITS-1:0] fill_ppn,
  input logic                    flush
);
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));

  p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[PG_BITS-1:0] == lk_vaddr[PG_BITS-1:0]));

  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_paddr == '0));

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  p_fill_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=>
      (!(lk_valid && lk_vaddr[VA_W-1:PG_BITS] == $past(fill_vpn)) ||
       (lk_hit && lk_paddr[PA_W-1:PG_BITS] == $past(fill_ppn))));
endmodule

bind tlb_fa tlb_fa_chk #(.VA_W(VA_W), .PA_W(PA_W), .PG_BITS(PG_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
  .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .flush(flush)
);

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        lk_valid = 0, fill_en = 0, flush = 0;
  logic [31:0] lk_vaddr = '0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_paddr;
  int          n_chk = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  tlb_fa #(.ENTRIES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .flush(flush)
  );

  task automatic look(input logic [31:0] va, input logic exp_hit,
                      input logic [31:0] exp_pa, input string req);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va;
    #1;
    n_chk++;
    if (lk_hit !== exp_hit || lk_miss !== !exp_hit || lk_paddr !== (exp_hit ? exp_pa : 32'h0)) begin
      n_bad++;
      $display("FAIL %s va=%h: hit=%b miss=%b pa=%h expected hit=%b pa=%h",
               req, va, lk_hit, lk_miss, lk_paddr, exp_hit, exp_hit ? exp_pa : 32'h0);
    end
    lk_valid = 0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p);
    @(negedge clk);
    fill_en = 1; fill_vpn = v; fill_ppn = p;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  function automatic logic [31:0] pa(input logic [19:0] p, input logic [11:0] o);
    return {p, o};
  endfunction

  task automatic t_reset();
    repeat (2) @(negedge clk);
    lk_valid = 1; lk_vaddr = 32'h1234_5678; #1;
    n_chk++;
    if (!lk_miss || lk_hit) begin
      n_bad++; $display("FAIL R5 in reset: hit=%b miss=%b expected hit=0 miss=1", lk_hit, lk_miss);
    end
    lk_valid = 0;
    @(negedge clk); rst_n = 1;
    look(32'h1234_5678, 0, 0, "R5");
  endtask

  task automatic t_idle();
    fill(20'hFC519, 20'h00152);
    @(negedge clk); lk_valid = 0; lk_vaddr = 32'hFC51_908B; #1;
    n_chk++;
    if (lk_hit || lk_miss) begin
      n_bad++; $display("FAIL R4 idle: hit=%b miss=%b expected 0 0", lk_hit, lk_miss);
    end
  endtask

  task automatic t_basic();
    look(32'hFC51_908B, 1, 32'h0015_208B, "R2");
    look(32'hFC51_9FFF, 1, 32'h0015_2FFF, "R1");
    look(32'hFC51_9000, 1, 32'h0015_2000, "R1");
    look(32'hFC51_A08B, 0, 0, "R3");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    fill_en = 1; fill_vpn = 20'hABCDE; fill_ppn = 20'h11111;
    lk_valid = 1; lk_vaddr = 32'hABCD_E123; #1;
    n_chk++;
    if (!lk_miss || lk_hit) begin
      n_bad++; $display("FAIL R6 same cycle: hit=%b miss=%b expected hit=0 miss=1", lk_hit, lk_miss);
    end
    @(negedge clk); fill_en = 0; #1;
    n_chk++;
    if (!lk_hit || lk_paddr !== 32'h1111_1123) begin
      n_bad++; $display("FAIL R6 next cycle: hit=%b pa=%h expected hit=1 pa=11111123", lk_hit, lk_paddr);
    end
    lk_valid = 0;
  endtask

  task automatic fill4();
    do_flush();
    for (int i = 0; i < 4; i++) fill(20'h00A00 + 20'(i), 20'h0B000 + 20'(i));
  endtask

  task automatic t_free();
    fill4();
    for (int i = 0; i < 4; i++) look({20'h00A00 + 20'(i), 12'h040}, 1, pa(20'h0B000 + 20'(i), 12'h040), "R7");
  endtask

  task automatic t_rr();
    fill(20'h00E00, 20'h0E000);
    look(32'h00A0_0004, 0, 0, "R8");
    look(32'h00E0_0004, 1, 32'h0E00_0004, "R8");
    look(32'h00A0_1004, 1, 32'h0B00_1004, "R8");
    fill(20'h00E01, 20'h0E001);
    look(32'h00A0_1004, 0, 0, "R8");
    look(32'h00A0_2004, 1, 32'h0B00_2004, "R8");
    fill(20'h00E02, 20'h0E002);
    fill(20'h00E03, 20'h0E003);
    fill(20'h00E04, 20'h0E004);
    look(32'h00E0_0004, 0, 0, "R8");
    look(32'h00E0_1004, 1, 32'h0E00_1004, "R8");
    look(32'h00E0_4004, 1, 32'h0E00_4004, "R8");
  endtask

  task automatic t_dup();
    fill4();
    fill(20'h00A01, 20'h0C0DE);
    look(32'h00A0_1010, 1, 32'h0C0D_E010, "R10");
    look(32'h00A0_0010, 1, 32'h0B00_0010, "R10");
    look(32'h00A0_3010, 1, 32'h0B00_3010, "R10");
    fill(20'h00F00, 20'h0F000);
    look(32'h00A0_0010, 0, 0, "R10");
    look(32'h00A0_1010, 1, 32'h0C0D_E010, "R10");
  endtask

  task automatic t_flush();
    fill4();
    fill(20'h00E00, 20'h0E000);
    @(negedge clk);
    flush = 1; fill_en = 1; fill_vpn = 20'h77777; fill_ppn = 20'h12345;
    @(negedge clk);
    flush = 0; fill_en = 0;
    look(32'h7777_7000, 0, 0, "R9");
    look(32'h00E0_0000, 0, 0, "R9");
    look(32'h00A0_1000, 0, 0, "R9");
    for (int i = 0; i < 4; i++) fill(20'h00A00 + 20'(i), 20'h0B000 + 20'(i));
    fill(20'h00F00, 20'h0F000);
    look(32'h00A0_0000, 0, 0, "R9");
    look(32'h00A0_1000, 1, 32'h0B00_1000, "R9");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_idle();
    t_basic();
    t_same_cycle();
    t_free();
    t_rr();
    t_dup();
    t_flush();
    summary();
  end

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end
endmodule